// File: doc/BRIEF.md
# RGB Blanking and Service Pattern Selector

This block sits in the digital control path of a CRT RGB output stage. Each line is 256 pixel-clock ticks long. From the current tick and line counts it forms a composite blanking gate. The gate has four sources:

- a left edge of programmable width;
- a right edge of programmable width;
- an optional OR with the external flyback pulse;
- one of two vertical active windows.

Every cycle the block then picks the source for the RGB drivers: normal video, black, full white, 60% gray or the blanking level. A two-bit service selector can replace the video with a black field, a white or gray field, or a crosshatch grid for alignment on the production line.

A video-mute control and a blank-defeat control override the normal chain. The order of precedence is mute, then blanking, then the service pattern, then live video. All three outputs come from one register stage, so each output reflects the inputs sampled on the previous clock edge.

Top module: `crt_blank_pattern_gen`

## Requirements
- R1: With tick values 0 to 255, a tick below 16 + 4·`lft_width_i` is in the horizontal blanking gate.
- R2: A tick at or above 240 − 4·`rgt_width_i` is in the horizontal blanking gate.
- R3: When `fly_or_en_i` = 1, an active `flyback_i` also puts the current tick in the horizontal blanking gate. When `fly_or_en_i` = 0, `flyback_i` has no effect.
- R4: With `vwin_sel_i` = 0, lines 24 to 262 inclusive are active. With `vwin_sel_i` = 1, lines 29 to 257 are active. Every other line is vertically blanked.
- R5: `blank_o` is the OR of the horizontal and vertical gates, forced to 0 while `blank_defeat_i` = 1. Whenever `blank_o` = 1, `pix_sel_o` = 4 (blanking level).
- R6: While `mute_i` = 1, `mute_o` = 1 and `pix_sel_o` = 4, whatever the other inputs.
- R7: Outside mute and blanking, `svc_mode_i` selects the output code on `pix_sel_o`, as follows:
  - 00 gives 0 (video);
  - 01 gives 1 (black);
  - 10 gives 2 (white) when `gray_i` = 0 and 3 (gray) when `gray_i` = 1.
- R8: With `svc_mode_i` = 11, a point whose tick mod 32 = 0 or whose line mod 32 = 0 gets the white code (2, or 3 when `gray_i` = 1). All other points get 1 (black).
- R9: Each output reflects the inputs sampled at the previous rising clock edge. During reset the outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, 256 ticks per line |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 8 | Horizontal tick count within the line |
| line_i | input | 10 | Line count within the field |
| flyback_i | input | 1 | External flyback pulse flag |
| lft_width_i | input | 3 | Left blanking width step |
| rgt_width_i | input | 3 | Right blanking width step |
| vwin_sel_i | input | 1 | Vertical active window select |
| fly_or_en_i | input | 1 | OR the flyback pulse into horizontal blanking |
| blank_defeat_i | input | 1 | Remove all blanking |
| mute_i | input | 1 | Video mute |
| svc_mode_i | input | 2 | Service pattern select |
| gray_i | input | 1 | Use 60% level for white |
| blank_o | output | 1 | Composite blanking flag |
| mute_o | output | 1 | Mute flag |
| pix_sel_o | output | 3 | Pixel source code: 0 video, 1 black, 2 white, 3 gray, 4 blanking level |

## Verification
A wrong edge comparison or window bound shows up as a misplaced `blank_o` transition. This appears one cycle after the offending tick or line is presented, so a full sweep of ticks and lines exposes every off-by-one. A fault in the priority chain or the pattern decode gives a wrong `pix_sel_o` code on the very next cycle. These are checked point by point, including the grid lines of the crosshatch. Because every output passes through exactly one register, a missing or extra stage shifts each result by a cycle and breaks every check.

// File: rtl/crt_blank_pkg.sv
package crt_blank_pkg;
  typedef enum logic [2:0] {
    PIX_VIDEO = 3'd0,
    PIX_BLACK = 3'd1,
    PIX_WHITE = 3'd2,
    PIX_GRAY  = 3'd3,
    PIX_BLANK = 3'd4
  } pix_src_t;

  localparam logic [1:0] SVC_NORMAL = 2'b00;
  localparam logic [1:0] SVC_BLACK  = 2'b01;
  localparam logic [1:0] SVC_WHITE  = 2'b10;
  localparam logic [1:0] SVC_GRID   = 2'b11;
endpackage

// File: rtl/hblank_gate.sv
module hblank_gate #(
  parameter int TICK_W     = 8,
  parameter int WSTEP_W    = 3,
  parameter int LEFT_BASE  = 16,
  parameter int RIGHT_BASE = 240,
  parameter int STEP_SH    = 2
) (
  input  logic [TICK_W-1:0]  tick_i,
  input  logic [WSTEP_W-1:0] lft_width_i,
  input  logic [WSTEP_W-1:0] rgt_width_i,
  input  logic               flyback_i,
  input  logic               fly_or_en_i,
  output logic               hblank_o
);
  localparam int EW = TICK_W + 2;

  logic [EW-1:0] left_end;
  logic [EW-1:0] right_start;
  logic [EW-1:0] tick_ext;
  logic          in_left;
  logic          in_right;

  always_comb begin
    tick_ext    = EW'(tick_i);
    left_end    = EW'(LEFT_BASE) + (EW'(lft_width_i) << STEP_SH);
    right_start = EW'(RIGHT_BASE) - (EW'(rgt_width_i) << STEP_SH);
    in_left     = tick_ext < left_end;
    in_right    = tick_ext >= right_start;
    hblank_o    = in_left | in_right | (fly_or_en_i & flyback_i);
  end
endmodule

// File: rtl/vblank_gate.sv
module vblank_gate #(
  parameter int LINE_W  = 10,
  parameter int A_FIRST = 24,
  parameter int A_LAST  = 262,
  parameter int B_FIRST = 29,
  parameter int B_LAST  = 257
) (
  input  logic [LINE_W-1:0] line_i,
  input  logic              vwin_sel_i,
  output logic              vblank_o
);
  localparam int NWIN = 2;
  localparam int FIRSTS [NWIN] = '{A_FIRST, B_FIRST};
  localparam int LASTS  [NWIN] = '{A_LAST, B_LAST};

  logic [NWIN-1:0] outside;

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    assign outside[w] = (line_i < LINE_W'(FIRSTS[w])) ||
                        (line_i > LINE_W'(LASTS[w]));
  end

  assign vblank_o = outside[vwin_sel_i];
endmodule

// File: rtl/svc_pattern.sv
module svc_pattern
  import crt_blank_pkg::*;
#(
  parameter int TICK_W  = 8,
  parameter int LINE_W  = 10,
  parameter int GRID_SH = 5
) (
  input  logic [TICK_W-1:0] tick_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic [1:0]        svc_mode_i,
  input  logic              gray_i,
  output pix_src_t          pix_o
);
  pix_src_t light;
  logic     on_grid;

  always_comb begin
    light   = gray_i ? PIX_GRAY : PIX_WHITE;
    on_grid = (tick_i[GRID_SH-1:0] == '0) || (line_i[GRID_SH-1:0] == '0);
    unique case (svc_mode_i)
      SVC_NORMAL: pix_o = PIX_VIDEO;
      SVC_BLACK:  pix_o = PIX_BLACK;
      SVC_WHITE:  pix_o = light;
      default:    pix_o = on_grid ? light : PIX_BLACK;
    endcase
  end
endmodule

// File: rtl/crt_blank_pattern_gen.sv
module crt_blank_pattern_gen
  import crt_blank_pkg::*;
#(
  parameter int TICKS_PER_LINE = 256,
  parameter int LINE_W         = 10,
  parameter int WSTEP_W        = 3,
  parameter int GRID_SH        = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [$clog2(TICKS_PER_LINE)-1:0] tick_i,
  input  logic [LINE_W-1:0]           line_i,
  input  logic                        flyback_i,
  input  logic [WSTEP_W-1:0]          lft_width_i,
  input  logic [WSTEP_W-1:0]          rgt_width_i,
  input  logic                        vwin_sel_i,
  input  logic                        fly_or_en_i,
  input  logic                        blank_defeat_i,
  input  logic                        mute_i,
  input  logic [1:0]                  svc_mode_i,
  input  logic                        gray_i,
  output logic                        blank_o,
  output logic                        mute_o,
  output logic [2:0]                  pix_sel_o
);
  localparam int TICK_W = $clog2(TICKS_PER_LINE);

  logic     hblank;
  logic     vblank;
  pix_src_t pat_pix;

  logic     blank_d, blank_q;
  logic     mute_d,  mute_q;
  pix_src_t pix_d,   pix_q;
  logic     upd_en;

  hblank_gate #(
    .TICK_W (TICK_W),
    .WSTEP_W(WSTEP_W)
  ) u_hgate (
    .tick_i     (tick_i),
    .lft_width_i(lft_width_i),
    .rgt_width_i(rgt_width_i),
    .flyback_i  (flyback_i),
    .fly_or_en_i(fly_or_en_i),
    .hblank_o   (hblank)
  );

  vblank_gate #(.LINE_W(LINE_W)) u_vgate (
    .line_i    (line_i),
    .vwin_sel_i(vwin_sel_i),
    .vblank_o  (vblank)
  );

  svc_pattern #(
    .TICK_W (TICK_W),
    .LINE_W (LINE_W),
    .GRID_SH(GRID_SH)
  ) u_pat (
    .tick_i    (tick_i),
    .line_i    (line_i),
    .svc_mode_i(svc_mode_i),
    .gray_i    (gray_i),
    .pix_o     (pat_pix)
  );

  // Next-state: mute, then blanking, then pattern/video.
  always_comb begin
    upd_en  = 1'b1;
    blank_d = (hblank | vblank) & ~blank_defeat_i;
    mute_d  = mute_i;
    if (mute_i)       pix_d = PIX_BLANK;
    else if (blank_d) pix_d = PIX_BLANK;
    else              pix_d = pat_pix;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blank_q <= 1'b0;
      mute_q  <= 1'b0;
      pix_q   <= PIX_VIDEO;
    end else if (upd_en) begin
      blank_q <= blank_d;
      mute_q  <= mute_d;
      pix_q   <= pix_d;
    end
  end

  assign blank_o   = blank_q;
  assign mute_o    = mute_q;
  assign pix_sel_o = pix_q;
endmodule

// File: rtl/crt_blank_pattern_chk.sv
module crt_blank_pattern_chk #(
  parameter int LINE_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic [LINE_W-1:0] line_i,
  input logic              blank_defeat_i,
  input logic              mute_i,
  input logic [1:0]        svc_mode_i,
  input logic              blank_o,
  input logic              mute_o,
  input logic [2:0]        pix_sel_o
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assert_mute_forces_blank_R6: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(mute_i) |-> mute_o && pix_sel_o == 3'd4);

  assert_defeat_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(blank_defeat_i) |-> !blank_o);

  assert_blank_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    armed && blank_o |-> pix_sel_o == 3'd4);

  assert_top_lines_blanked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(!blank_defeat_i && line_i < LINE_W'(24)) |-> blank_o);

  assert_normal_video_R7: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !mute_o && !blank_o && $past(svc_mode_i == 2'b00) |-> pix_sel_o == 3'd0);

  assert_black_field_R7: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !mute_o && !blank_o && $past(svc_mode_i == 2'b01) |-> pix_sel_o == 3'd1);

  assert_code_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pix_sel_o <= 3'd4);
endmodule

bind crt_blank_pattern_gen crt_blank_pattern_chk #(.LINE_W(LINE_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .line_i        (line_i),
  .blank_defeat_i(blank_defeat_i),
  .mute_i        (mute_i),
  .svc_mode_i    (svc_mode_i),
  .blank_o       (blank_o),
  .mute_o        (mute_o),
  .pix_sel_o     (pix_sel_o)
);

// File: tb/tb_crt_blank_pattern_gen.sv
module tb_crt_blank_pattern_gen;
  logic       clk;
  logic       rst_n;
  logic [7:0] tick_i;
  logic [9:0] line_i;
  logic       flyback_i;
  logic [2:0] lft_width_i, rgt_width_i;
  logic       vwin_sel_i, fly_or_en_i, blank_defeat_i, mute_i, gray_i;
  logic [1:0] svc_mode_i;
  logic       blank_o, mute_o;
  logic [2:0] pix_sel_o;

  int n_tests = 0;
  int n_fail  = 0;

  crt_blank_pattern_gen dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .line_i(line_i),
    .flyback_i(flyback_i), .lft_width_i(lft_width_i), .rgt_width_i(rgt_width_i),
    .vwin_sel_i(vwin_sel_i), .fly_or_en_i(fly_or_en_i),
    .blank_defeat_i(blank_defeat_i), .mute_i(mute_i), .svc_mode_i(svc_mode_i),
    .gray_i(gray_i), .blank_o(blank_o), .mute_o(mute_o), .pix_sel_o(pix_sel_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Returns {blank, mute, pix[2:0]} from the requirements.
  function automatic logic [4:0] model();
    int  t, l;
    logic hb, vb, bl;
    logic [2:0] lt, px;
    t  = int'(tick_i);
    l  = int'(line_i);
    hb = (t < 16 + 4 * int'(lft_width_i)) || (t >= 240 - 4 * int'(rgt_width_i)) ||
         (fly_or_en_i && flyback_i);
    vb = vwin_sel_i ? (l < 29 || l > 257) : (l < 24 || l > 262);
    bl = (hb || vb) && !blank_defeat_i;
    lt = gray_i ? 3'd3 : 3'd2;
    case (svc_mode_i)
      2'b00:   px = 3'd0;
      2'b01:   px = 3'd1;
      2'b10:   px = lt;
      default: px = ((t % 32) == 0 || (l % 32) == 0) ? lt : 3'd1;
    endcase
    if (mute_i || bl) px = 3'd4;
    return {bl, mute_i, px};
  endfunction

  task automatic check(input string req, input logic [4:0] exp);
    n_tests++;
    if ({blank_o, mute_o, pix_sel_o} !== exp) begin
      n_fail++;
      $display("FAIL %s tick=%0d line=%0d got blank=%b mute=%b pix=%0d exp blank=%b mute=%b pix=%0d",
               req, tick_i, line_i, blank_o, mute_o, pix_sel_o, exp[4], exp[3], exp[2:0]);
    end
  endtask

  // Inputs already driven; clock them in and compare one cycle later.
  task automatic step(input string req);
    logic [4:0] e;
    e = model();
    @(posedge clk);
    #1;
    check(req, e);
  endtask

  task automatic defaults();
    tick_i = 8'd128; line_i = 10'd100; flyback_i = 0;
    lft_width_i = 0; rgt_width_i = 0; vwin_sel_i = 0; fly_or_en_i = 0;
    blank_defeat_i = 0; mute_i = 0; svc_mode_i = 2'b00; gray_i = 0;
  endtask

  initial begin
    fork
      begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    join_none

    defaults();
    mute_i = 1; blank_defeat_i = 1; svc_mode_i = 2'b11;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset", 5'b0_0_000);
    defaults();
    rst_n = 1;
    step("R9 first");

    // R1/R2 horizontal edges
    for (int lw = 0; lw < 8; lw++) begin
      lft_width_i = 3'(lw);
      rgt_width_i = 3'((lw * 3 + 1) % 8);
      for (int t = 0; t < 256; t++) begin
        tick_i = 8'(t);
        step("R1/R2 hedge");
      end
    end
    defaults();

    // R4 vertical windows
    for (int vs = 0; vs < 2; vs++) begin
      vwin_sel_i = vs[0];
      for (int l = 0; l < 300; l++) begin
        line_i = 10'(l);
        step("R4 vwin");
      end
    end
    defaults();

    // R3 flyback OR
    for (int en = 0; en < 2; en++)
      for (int fb = 0; fb < 2; fb++)
        for (int t = 60; t < 200; t += 35) begin
          fly_or_en_i = en[0]; flyback_i = fb[0]; tick_i = 8'(t);
          step("R3 flyback");
        end
    defaults();

    // R5 blank defeat at blanked points
    blank_defeat_i = 1;
    for (int m = 0; m < 4; m++) begin
      svc_mode_i = 2'(m);
      tick_i = 8'd1;  line_i = 10'd3;   step("R5 defeat");
      tick_i = 8'd250; line_i = 10'd280; step("R5 defeat");
    end
    defaults();

    // R6 mute overrides everything
    mute_i = 1;
    for (int m = 0; m < 4; m++) begin
      svc_mode_i = 2'(m); blank_defeat_i = m[0];
      tick_i = 8'(m * 70); line_i = 10'(m * 90);
      step("R6 mute");
    end
    defaults();

    // R9 latency: a change is not visible before the next edge
    step("R9 prior");
    mute_i = 1;
    #2;
    check("R9 hold", {1'b0, 1'b0, 3'd0});
    step("R9 after");
    defaults();

    // R7/R8 service patterns, blanking defeated to expose every point
    blank_defeat_i = 1;
    for (int m = 1; m < 4; m++)
      for (int g = 0; g < 2; g++) begin
        svc_mode_i = 2'(m); gray_i = g[0];
        for (int l = 0; l < 34; l++)
          for (int t = 0; t < 256; t++) begin
            line_i = 10'(l); tick_i = 8'(t);
            step(m == 3 ? "R8 grid" : "R7 field");
          end
      end
    svc_mode_i = 2'b00;
    step("R7 video");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule